// File: doc/BRIEF.md
# Smart-Card Half-Duplex UART with Parity Error Signalling

This block is an asynchronous serial transceiver for a smart-card style link. Transmitter and receiver share a single open-drain line that an external resistor pulls high, so the block never drives a high level. It only asserts an output enable that pulls the line low, or it releases the line. Every character is framed as a low start bit, eight data bits with the least significant bit first, one even parity bit and a released stop bit. Each bit lasts a number of system clocks chosen at run time.

When the receiver collects a character whose parity is wrong, it can pull the shared line low from the start of the stop-bit period. This warns the far end that the character was corrupted. The low level is held until the receive buffer is read, and that read also clears the parity flag. When the transmitter finishes a character it issues a one-cycle completion pulse. Firmware samples the line at that moment to learn whether the far end returned an error signal.

Because the link is half-duplex, the receiver does not look for start bits while the transmitter is busy or while its own error signal holds the line low.

Top module: `sc_uart`

## Requirements
- R1: The transmit frame on `line_oe` is start (oe=1), then data bits 0 to 7 in that order (oe = inverse of the bit), then even parity over the eight data bits (oe = inverse of the parity), then stop (oe=0). Each bit lasts exactly `cfg_div` clocks. The line is released (`line_oe`=0) whenever neither the transmitter nor the error signal pulls it low.
- R2: `tx_start` is accepted only while `tx_busy` is 0. The clock edge that accepts it raises `tx_busy`, and `tx_data` is captured at that edge. A `tx_start` pulse while busy changes neither the frame being sent nor the timing.
- R3: `tx_done` is high for exactly one cycle after the clock edge that ends the stop bit, which is `11*cfg_div` edges after the accepting edge. `tx_busy` falls at that same edge. The line level at that moment shows whether the far end pulled it low during the stop bit.
- R4: A low level on `line_in` seen by the idle receiver at edge t0 is confirmed as a start bit only if the line is still low at edge t0+`cfg_div`/2 (integer division). Otherwise it is discarded with no flag change. Data and parity are sampled every `cfg_div` edges after that confirmation.
- R5: At edge t0+`10*cfg_div` the receiver loads `rx_data`, sets `rx_valid`, and sets `rx_parity_err` when the nine received bits (data plus parity) hold an odd number of ones.
- R6: With `err_sig_en`=1, a frame with a parity error asserts `line_oe` from that same edge. `line_oe` stays high until `rx_read` is sampled, and `rx_parity_err` is 1 for as long as the error signal is driven.
- R7: With `err_sig_en`=0, a parity error sets `rx_parity_err`, but the receiver never asserts `line_oe`.
- R8: The clock edge that samples `rx_read`=1 clears `rx_valid`, `rx_parity_err`, `rx_overrun` and the error signal.
- R9: A frame that completes while `rx_valid` is 1 and `rx_read` is 0 sets `rx_overrun`. It leaves `rx_data` and `rx_parity_err` unchanged and drives no error signal.
- R10: The receiver does not hunt for a start bit while `tx_busy` is 1 or while its own error signal is active. The block's own transmission and error signal therefore never produce a received frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_div | input | DIV_W | System clocks per bit, at least 4 |
| err_sig_en | input | 1 | 1 lets the receiver drive the error signal |
| tx_start | input | 1 | Request to send `tx_data` |
| tx_data | input | DATA_W | Character to send |
| tx_busy | output | 1 | Transmitter is sending a frame |
| tx_done | output | 1 | One-cycle pulse at the end of the stop bit |
| line_in | input | 1 | Level of the shared line |
| line_oe | output | 1 | 1 pulls the shared line low, 0 releases it |
| rx_read | input | 1 | Receive buffer read strobe |
| rx_data | output | DATA_W | Last accepted received character |
| rx_valid | output | 1 | Receive-complete flag |
| rx_parity_err | output | 1 | Parity error in the buffered character |
| rx_overrun | output | 1 | A frame arrived while the buffer was full |

## Verification
The bench goes after the edges of the error signal. A receiver that starts it one bit late, or releases it before the read, shows up as a `line_oe` mismatch in the stop bit or after the read. A receiver that keeps hunting while its own error signal holds the line would invent frames and raise overrun. Odd divider values, start glitches shorter than half a bit, a `tx_start` pulse in mid-frame, and back-to-back frames without a read each target a specific misbehaviour: a shifted sample point, a false frame, a corrupted outgoing character, or lost or overwritten buffer data.

// File: rtl/sc_uart_pkg.sv
package sc_uart_pkg;

  // Receiver sequencing: confirm start at mid-bit, sample data and parity,
  // wait to the stop-bit boundary, then hold through half of the stop bit.
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_WAIT,
    RX_STOP
  } rx_state_e;

endpackage

// File: rtl/sc_bit_timer.sv
module sc_bit_timer #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    tick = (cnt_q == limit);
    if (restart || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sc_uart_tx.sv
module sc_uart_tx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  div,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              drive_low,
  output logic              done
);

  localparam int unsigned FRAME_BITS = DATA_W + 3;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);

  logic                  busy_q, busy_d;
  logic                  done_q, done_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [FRAME_BITS-1:0] shift_q, shift_d;
  logic                  tick;

  sc_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (~busy_q),
    .limit   (div - 1'b1),
    .tick    (tick)
  );

  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    shift_d = shift_q;
    done_d  = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d  = 1'b1;
        idx_d   = '0;
        shift_d = {1'b1, ^data, data, 1'b0};
      end
    end else if (tick) begin
      if (idx_q == IDX_W'(FRAME_BITS - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        idx_d   = idx_q + 1'b1;
        shift_d = {1'b1, shift_q[FRAME_BITS-1:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
      shift_q <= '1;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      idx_q   <= idx_d;
      shift_q <= shift_d;
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign drive_low = busy_q & ~shift_q[0];

endmodule

// File: rtl/sc_uart_rx.sv
module sc_uart_rx
  import sc_uart_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  div,
  input  logic              hunt_ok,
  input  logic              line,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_perr
);

  localparam int unsigned SAMPLES = DATA_W + 1;
  localparam int unsigned IDX_W   = $clog2(SAMPLES);

  rx_state_e            state_q, state_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [SAMPLES-1:0]   shift_q, shift_d;
  logic [CNT_W-1:0]     half;
  logic [CNT_W-1:0]     limit;
  logic                 tick;

  assign half = div >> 1;

  always_comb begin
    case (state_q)
      RX_START, RX_STOP: limit = half - 1'b1;
      RX_WAIT:           limit = div - half - 1'b1;
      default:           limit = div - 1'b1;
    endcase
  end

  sc_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state_q == RX_IDLE),
    .limit   (limit),
    .tick    (tick)
  );

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    shift_d    = shift_q;
    frame_done = 1'b0;
    case (state_q)
      RX_IDLE: begin
        if (hunt_ok && !line) state_d = RX_START;
      end
      RX_START: begin
        if (tick) begin
          if (!line) begin
            state_d = RX_DATA;
            idx_d   = '0;
          end else begin
            state_d = RX_IDLE;
          end
        end
      end
      RX_DATA: begin
        if (tick) begin
          shift_d = {line, shift_q[SAMPLES-1:1]};
          if (idx_q == IDX_W'(SAMPLES - 1)) begin
            state_d = RX_WAIT;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      RX_WAIT: begin
        if (tick) begin
          frame_done = 1'b1;
          state_d    = RX_STOP;
        end
      end
      RX_STOP: begin
        if (tick) state_d = RX_IDLE;
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      idx_q   <= '0;
      shift_q <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      shift_q <= shift_d;
    end
  end

  assign frame_data = shift_q[DATA_W-1:0];
  assign frame_perr = ^shift_q;

endmodule

// File: rtl/sc_uart.sv
module sc_uart #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              err_sig_en,
  input  logic              tx_start,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_busy,
  output logic              tx_done,
  input  logic              line_in,
  output logic              line_oe,
  input  logic              rx_read,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_parity_err,
  output logic              rx_overrun
);

  logic [1:0]        rst_pipe_q;
  logic              rst_n_i;
  logic              tx_drive_low;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;
  logic              frame_perr;

  logic [DATA_W-1:0] data_q, data_d;
  logic              valid_q, valid_d;
  logic              perr_q, perr_d;
  logic              ovr_q, ovr_d;
  logic              err_oe_q, err_oe_d;

  // Reset asserts at once and leaves on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_i = rst_pipe_q[1];

  sc_uart_tx #(.DATA_W(DATA_W), .CNT_W(DIV_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .div       (cfg_div),
    .start     (tx_start),
    .data      (tx_data),
    .busy      (tx_busy),
    .drive_low (tx_drive_low),
    .done      (tx_done)
  );

  sc_uart_rx #(.DATA_W(DATA_W), .CNT_W(DIV_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .div        (cfg_div),
    .hunt_ok    (~tx_busy & ~err_oe_q),
    .line       (line_in),
    .frame_done (frame_done),
    .frame_data (frame_data),
    .frame_perr (frame_perr)
  );

  // Buffer and flags: a read frees the buffer before a completing frame is judged.
  always_comb begin
    data_d   = data_q;
    valid_d  = valid_q;
    perr_d   = perr_q;
    ovr_d    = ovr_q;
    err_oe_d = err_oe_q;
    if (rx_read) begin
      valid_d  = 1'b0;
      perr_d   = 1'b0;
      ovr_d    = 1'b0;
      err_oe_d = 1'b0;
    end
    if (frame_done) begin
      if (valid_d) begin
        ovr_d = 1'b1;
      end else begin
        data_d   = frame_data;
        valid_d  = 1'b1;
        perr_d   = frame_perr;
        err_oe_d = frame_perr & err_sig_en;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      data_q   <= '0;
      valid_q  <= 1'b0;
      perr_q   <= 1'b0;
      ovr_q    <= 1'b0;
      err_oe_q <= 1'b0;
    end else begin
      data_q   <= data_d;
      valid_q  <= valid_d;
      perr_q   <= perr_d;
      ovr_q    <= ovr_d;
      err_oe_q <= err_oe_d;
    end
  end

  assign rx_data       = data_q;
  assign rx_valid      = valid_q;
  assign rx_parity_err = perr_q;
  assign rx_overrun    = ovr_q;
  assign line_oe       = tx_drive_low | err_oe_q;

endmodule

// File: rtl/sc_uart_chk.sv
module sc_uart_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              err_sig_en,
  input logic              rx_read,
  input logic              frame_done,
  input logic              err_oe,
  input logic              rx_valid,
  input logic              rx_parity_err,
  input logic              rx_overrun,
  input logic [DATA_W-1:0] rx_data,
  input logic              tx_busy,
  input logic              tx_done
);

  // R3: completion pulse follows the last busy cycle
  p_done_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!tx_busy && $past(tx_busy)));

  // R3: completion pulse lasts one cycle
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  // R5: a frame into a free buffer leaves it valid
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && (!rx_valid || rx_read)) |=> rx_valid);

  // R6: the error signal is never driven without a flagged parity error
  p_err_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_oe |-> rx_parity_err);

  // R7: the error signal only starts while enabled
  p_err_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_oe) |-> $past(err_sig_en));

  // R8: a read with no completing frame clears every flag
  p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_read && !frame_done) |=> (!rx_valid && !rx_parity_err && !rx_overrun && !err_oe));

  // R9: a frame into a full buffer sets overrun and keeps the data
  p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_valid && !rx_read) |=> (rx_overrun && $stable(rx_data)));

endmodule

bind sc_uart sc_uart_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n_i),
  .err_sig_en    (err_sig_en),
  .rx_read       (rx_read),
  .frame_done    (frame_done),
  .err_oe        (err_oe_q),
  .rx_valid      (valid_q),
  .rx_parity_err (perr_q),
  .rx_overrun    (ovr_q),
  .rx_data       (data_q),
  .tx_busy       (tx_busy),
  .tx_done       (tx_done)
);

// File: tb/sc_uart_tb.sv
module sc_uart_tb;

  localparam int DIV_W = 12;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [DIV_W-1:0] cfg_div;
  logic             err_sig_en;
  logic             tx_start;
  logic [7:0]       tx_data;
  logic             tx_busy, tx_done;
  logic             line_in, line_oe;
  logic             rx_read;
  logic [7:0]       rx_data;
  logic             rx_valid, rx_parity_err, rx_overrun;
  logic             card_low;

  always #10 clk = ~clk;

  // Open-drain wire with pull-up: low if either side pulls.
  assign line_in = ~(line_oe | card_low);

  sc_uart u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_div       (cfg_div),
    .err_sig_en    (err_sig_en),
    .tx_start      (tx_start),
    .tx_data       (tx_data),
    .tx_busy       (tx_busy),
    .tx_done       (tx_done),
    .line_in       (line_in),
    .line_oe       (line_oe),
    .rx_read       (rx_read),
    .rx_data       (rx_data),
    .rx_valid      (rx_valid),
    .rx_parity_err (rx_parity_err),
    .rx_overrun    (rx_overrun)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  bit model_on = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_cyc, m_last, m_ts, m_t0;
  bit          m_tb, m_td, m_ra, m_v, m_pe, m_ov, m_eo;
  logic [10:0] m_fr;
  logic [8:0]  m_bits;
  logic [7:0]  m_d;

  always @(posedge clk) begin : model
    int d, h, rel;
    bit busy_old, oe_old, complete;
    if (!model_on) begin
      m_cyc = 0; m_last = 0; m_ts = 0; m_t0 = 0;
      m_tb = 0; m_td = 0; m_ra = 0; m_v = 0; m_pe = 0; m_ov = 0; m_eo = 0;
      m_fr = '1; m_bits = '0; m_d = '0;
    end else begin
      d = int'(cfg_div);
      h = d / 2;
      busy_old = m_tb;
      oe_old   = m_eo;
      complete = 0;
      if (!m_ra) begin
        if (!busy_old && !oe_old && !line_in) begin
          m_ra = 1;
          m_t0 = m_cyc;
        end
      end else begin
        rel = m_cyc - m_t0;
        if (rel == h) begin
          if (line_in) m_ra = 0;
        end else if (rel > h && rel <= h + 9*d && ((rel - h) % d) == 0) begin
          m_bits[(rel - h)/d - 1] = line_in;
        end else if (rel == 10*d) begin
          complete = 1;
        end else if (rel == 10*d + h) begin
          m_ra = 0;
        end
      end
      if (rx_read) begin
        m_v = 0; m_pe = 0; m_ov = 0; m_eo = 0;
      end
      if (complete) begin
        if (m_v) begin
          m_ov = 1;
        end else begin
          m_v  = 1;
          m_d  = m_bits[7:0];
          m_pe = ^m_bits;
          m_eo = m_pe & err_sig_en;
        end
      end
      m_td = 0;
      if (busy_old) begin
        if (m_cyc - m_ts == 11*d) begin
          m_tb = 0;
          m_td = 1;
        end
      end else if (tx_start) begin
        m_tb = 1;
        m_ts = m_cyc;
        m_fr = {1'b1, ^tx_data, tx_data, 1'b0};
      end
      m_last = m_cyc;
      m_cyc++;
    end
  end

  always @(negedge clk) begin : compare
    int d;
    logic e_oe;
    if (model_on && !finished) begin
      d = int'(cfg_div);
      e_oe = m_eo | (m_tb && !m_fr[(m_last - m_ts)/d]);
      check("R1/R6", "line_oe", line_oe, e_oe);
      check("R2", "tx_busy", tx_busy, m_tb);
      check("R3", "tx_done", tx_done, m_td);
      check("R5", "rx_valid", rx_valid, m_v);
      check("R5", "rx_parity_err", rx_parity_err, m_pe);
      check("R9", "rx_overrun", rx_overrun, m_ov);
      if (m_v) check("R5", "rx_data", rx_data, m_d);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic tx_frame(input logic [7:0] d, input bit card_err, input bit poke);
    int dv, hv;
    logic [10:0] fr;
    dv = int'(cfg_div);
    hv = dv / 2;
    fr = {1'b1, ^d, d, 1'b0};
    @(posedge clk); #2 tx_data = d; tx_start = 1;
    @(posedge clk); #2 tx_start = 0;
    for (int j = 0; j < 11; j++) begin
      repeat (j == 0 ? hv : dv) @(posedge clk);
      #2;
      tx_start = 0;
      if (poke && j == 3) begin
        tx_data  = ~d;
        tx_start = 1;
      end
      if (card_err && j == 10) card_low = 1;
      @(negedge clk);
      check("R1", "frame bit on line_oe", line_oe, !fr[j]);
    end
    repeat (dv - hv) @(posedge clk);
    @(negedge clk);
    check("R3", "tx_done at stop end", tx_done, 1);
    check("R3", "tx_busy at stop end", tx_busy, 0);
    if (card_err) check("R3", "returned error seen at done", line_in, 0);
    card_low = 0;
    @(negedge clk);
    check("R3", "tx_done single cycle", tx_done, 0);
  endtask

  task automatic rx_frame(input logic [7:0] d, input bit bad);
    int dv;
    logic [10:0] fr;
    dv = int'(cfg_div);
    fr = {1'b1, (^d) ^ bad, d, 1'b0};
    @(posedge clk); #2;
    for (int b = 0; b < 11; b++) begin
      card_low = !fr[b];
      repeat (dv) @(posedge clk);
      #2;
    end
    card_low = 0;
    @(negedge clk);
  endtask

  task automatic do_read();
    @(posedge clk); #2 rx_read = 1;
    @(posedge clk); #2 rx_read = 0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_div = 8; err_sig_en = 1; tx_start = 0; tx_data = 0;
    rx_read = 0; card_low = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) @(posedge clk);
    #2 model_on = 1;
    @(negedge clk);
    check("R1", "reset line_oe", line_oe, 0);
    check("R2", "reset tx_busy", tx_busy, 0);
    check("R5", "reset rx_valid", rx_valid, 0);
    check("R9", "reset rx_overrun", rx_overrun, 0);

    // R1 R2 R10: send with a mid-frame start pulse; own frame not received
    tx_frame(8'hA5, 0, 1);
    repeat (96) @(posedge clk);
    @(negedge clk);
    check("R10", "no reception of own frame", rx_valid, 0);

    // R3: far end returns an error signal during the stop bit
    tx_frame(8'h3C, 1, 0);

    // R4 R5: clean reception
    rx_frame(8'h5A, 0);
    check("R5", "rx_valid", rx_valid, 1);
    check("R5", "rx_data", rx_data, 8'h5A);
    check("R5", "no parity error", rx_parity_err, 0);
    check("R6", "no error signal on good frame", line_oe, 0);
    do_read();
    check("R8", "valid cleared", rx_valid, 0);

    // R6 R10: bad parity with signalling enabled
    rx_frame(8'h96, 1);
    check("R5", "parity error flagged", rx_parity_err, 1);
    check("R6", "error signal driven", line_oe, 1);
    check("R6", "line held low", line_in, 0);
    repeat (40) @(posedge clk);
    @(negedge clk);
    check("R6", "error signal held", line_oe, 1);
    check("R10", "no hunt during error signal", rx_overrun, 0);
    do_read();
    check("R8", "error signal released", line_oe, 0);
    check("R8", "parity flag cleared", rx_parity_err, 0);
    check("R8", "valid cleared after error", rx_valid, 0);

    // R7: signalling disabled
    @(posedge clk); #2 err_sig_en = 0;
    rx_frame(8'h0F, 1);
    check("R7", "flag without signal", rx_parity_err, 1);
    check("R7", "line not driven", line_oe, 0);
    check("R7", "data kept", rx_data, 8'h0F);
    do_read();
    @(posedge clk); #2 err_sig_en = 1;

    // R4: glitch shorter than half a bit
    @(posedge clk); #2 card_low = 1;
    repeat (2) @(posedge clk);
    #2 card_low = 0;
    repeat (24) @(posedge clk);
    @(negedge clk);
    check("R4", "glitch rejected", rx_valid, 0);

    // R9: overrun keeps the first character
    rx_frame(8'h11, 0);
    rx_frame(8'h22, 0);
    check("R9", "overrun set", rx_overrun, 1);
    check("R9", "first data kept", rx_data, 8'h11);
    rx_frame(8'h33, 1);
    check("R9", "no error signal on overrun frame", line_oe, 0);
    check("R9", "parity flag unchanged", rx_parity_err, 0);
    check("R9", "data still kept", rx_data, 8'h11);
    do_read();
    check("R8", "overrun cleared", rx_overrun, 0);

    // R4 R1: odd divider
    @(posedge clk); #2 cfg_div = 5;
    rx_frame(8'hC3, 0);
    check("R4", "odd divider reception", rx_valid, 1);
    check("R4", "odd divider data", rx_data, 8'hC3);
    do_read();
    tx_frame(8'h81, 0, 0);
    @(posedge clk); #2 cfg_div = 8;

    repeat (10) @(posedge clk);
    finish_run();
  end

endmodule